// File: doc/BRIEF.md
# Background Read Sequencer with Result Queue

This block fetches a run of data items from an external half-duplex port while the processor carries on with other work. Software loads a start address, an access width and a number of reads in one step. The engine then issues one external read at a time. Each read holds a strobe for a fixed number of cycles, and the engine captures the returned data on the last cycle of that strobe. The captured value is reduced to the chosen width and written into a small internal queue. The engine then moves the address on by the access width.

The engine gives way to traffic that it does not own. While the posted-write buffer holds entries, or while the external device reports that it has nothing to give, no new read is launched. A read already under way always completes. When the queue is full the engine stops launching reads and loses no data. It continues as entries are popped. A fill threshold on the queue drives an interrupt line, a DMA request line, or both, and each line is gated by its own enable. Software takes results one at a time through a pop port. A pop of an empty queue returns zero and sets a sticky flag.

Top module: `nbr_engine`

## Requirements
- R1: Out of reset there is no strobe, the remaining count is 0, the fill level is 0, and irq, dmaReq and underflow are all low.
- R2: A load with a nonzero count makes the engine carry out exactly that many reads. Each read holds rdStrobe high for RD_CYCLES cycles with rdAddr held steady. After each read rdAddr advances by 1, 2 or 4 for ldSize codes 0 (byte), 1 (half) and 2 (word). Code 3 advances by 4.
- R3: Every completed read pushes one entry. The entry holds extData as sampled in the last strobe cycle, zero-extended from bits [7:0] for size 0, from bits [15:0] for size 1, and taken as all 32 bits for sizes 2 and 3.
- R4: No read is launched in a cycle where wrPending is high. A read already in flight is not disturbed by wrPending.
- R5: No read is launched in a cycle where extEmpty is high, and waiting in that state does not consume any count.
- R6: The queue holds DEPTH entries. While it is full the engine launches nothing, and no result is lost. Launching resumes once entries have been popped.
- R7: remCount reads back live. It takes the loaded value and drops by one on each push while it is above zero.
- R8: A load with a count of zero changes only the count. It stops further launches, and a read already in flight still completes and pushes its result.
- R9: irq is high exactly when intEn is set and fillLevel >= thresh. dmaReq is high exactly when dmaEn is set and fillLevel >= thresh. With both enables clear, the threshold has no effect.
- R10: popData shows the oldest entry in the same cycle that popReq is high, and entries leave in arrival order. A pop of an empty queue returns 0 and sets underflow, which stays high until reset.
- R11: At most one read is in flight at a time, and at least one cycle with rdStrobe low separates two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Load strobe for address, size and count |
| ldAddr | input | AW | Start address |
| ldSize | input | 2 | Access width code |
| ldCount | input | CW | Number of reads; 0 stops the engine |
| remCount | output | CW | Reads still to complete |
| wrPending | input | 1 | Posted-write buffer not empty |
| extEmpty | input | 1 | External device has no data |
| rdStrobe | output | 1 | External read strobe |
| rdAddr | output | AW | External read address |
| rdSize | output | 2 | Access width of the current sequence |
| extData | input | DW | External read data |
| popReq | input | 1 | Pop one result |
| popData | output | DW | Popped result, or 0 when the queue is empty |
| fillLevel | output | LW | Queue occupancy |
| underflow | output | 1 | Sticky empty-pop flag |
| thresh | input | LW | Fill threshold |
| intEn | input | 1 | Interrupt enable |
| dmaEn | input | 1 | DMA request enable |
| irq | output | 1 | Threshold interrupt |
| dmaReq | output | 1 | Threshold DMA request |

## Verification
The bench uses DEPTH 8, RD_CYCLES 3, AW 16, DW 32 and CW 8. The shallow queue lets a sequence of twelve reads fill it and stall within a few dozen cycles, and it makes threshold 8 coincide with full. A three-cycle strobe leaves room to raise a stop load and wrPending in the middle of a read, and to check that the address holds steady across the strobe.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

  typedef struct packed {
    logic load;     // take new address and size
    logic launch;   // start an external read
    logic capture;  // last strobe cycle: sample and push
  } nbrStrobes_t;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;

endpackage

// File: rtl/nbr_fifo.sv
module nbr_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign empty  = (level == '0);
  assign full   = (level == LW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = store[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/nbr_ctrl.sv
module nbr_ctrl
  import nbr_pkg::*;
#(
  parameter int CW        = 8,
  parameter int RD_CYCLES = 3,
  localparam int TW       = (RD_CYCLES > 1) ? $clog2(RD_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ldValid,
  input  logic [CW-1:0] ldCount,
  input  logic          wrPending,
  input  logic          extEmpty,
  input  logic          fifoFull,
  output nbrStrobes_t   strobes,
  output logic          busy,
  output logic [CW-1:0] remCount
);

  logic [TW-1:0] timer;
  logic          launch, capture;

  // a new read needs: work left, bus free of writes, data available, room
  assign launch  = !busy && (remCount != '0) && !wrPending && !extEmpty && !fifoFull;
  assign capture = busy && (timer == '0);

  assign strobes.load    = ldValid && (ldCount != '0);
  assign strobes.launch  = launch;
  assign strobes.capture = capture;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      timer <= '0;
    end else if (launch) begin
      busy  <= 1'b1;
      timer <= TW'(RD_CYCLES - 1);
    end else if (capture) begin
      busy  <= 1'b0;
    end else if (busy) begin
      timer <= timer - TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                           remCount <= '0;
    else if (ldValid)                    remCount <= ldCount;
    else if (capture && remCount != '0)  remCount <= remCount - CW'(1);
  end

endmodule

// File: rtl/nbr_datapath.sv
module nbr_datapath
  import nbr_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  nbrStrobes_t   strobes,
  input  logic [AW-1:0] ldAddr,
  input  logic [1:0]    ldSize,
  input  logic [DW-1:0] extData,
  input  logic          popReq,
  output logic [AW-1:0] rdAddr,
  output logic [1:0]    rdSize,
  output logic [DW-1:0] popData,
  output logic [LW-1:0] fillLevel,
  output logic          fifoFull,
  output logic          underflow
);

  logic [DW-1:0] shaped, head;
  logic [AW-1:0] step;
  logic          fifoEmpty;

  always_comb begin
    shaped = '0;
    case (rdSize)
      SIZE_BYTE: shaped[7:0]  = extData[7:0];
      SIZE_HALF: shaped[15:0] = extData[15:0];
      default:   shaped       = extData;
    endcase
  end

  always_comb begin
    case (rdSize)
      SIZE_BYTE: step = AW'(1);
      SIZE_HALF: step = AW'(2);
      default:   step = AW'(4);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr <= '0;
      rdSize <= SIZE_BYTE;
    end else if (strobes.load) begin
      rdAddr <= ldAddr;
      rdSize <= ldSize;
    end else if (strobes.capture) begin
      rdAddr <= rdAddr + step;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     underflow <= 1'b0;
    else if (popReq && fifoEmpty)  underflow <= 1'b1;
  end

  assign popData = (popReq && !fifoEmpty) ? head : '0;

  nbr_fifo #(.DEPTH(DEPTH), .DW(DW)) i_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobes.capture),
    .pushData (shaped),
    .pop      (popReq),
    .head     (head),
    .level    (fillLevel),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

endmodule

// File: rtl/nbr_engine.sv
module nbr_engine
  import nbr_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int CW        = 8,
  parameter int DEPTH     = 8,
  parameter int RD_CYCLES = 3,
  localparam int LW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ldValid,
  input  logic [AW-1:0] ldAddr,
  input  logic [1:0]    ldSize,
  input  logic [CW-1:0] ldCount,
  output logic [CW-1:0] remCount,
  input  logic          wrPending,
  input  logic          extEmpty,
  output logic          rdStrobe,
  output logic [AW-1:0] rdAddr,
  output logic [1:0]    rdSize,
  input  logic [DW-1:0] extData,
  input  logic          popReq,
  output logic [DW-1:0] popData,
  output logic [LW-1:0] fillLevel,
  output logic          underflow,
  input  logic [LW-1:0] thresh,
  input  logic          intEn,
  input  logic          dmaEn,
  output logic          irq,
  output logic          dmaReq
);

  nbrStrobes_t strobes;
  logic        fifoFull;
  logic        atLevel;

  nbr_ctrl #(.CW(CW), .RD_CYCLES(RD_CYCLES)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ldValid   (ldValid),
    .ldCount   (ldCount),
    .wrPending (wrPending),
    .extEmpty  (extEmpty),
    .fifoFull  (fifoFull),
    .strobes   (strobes),
    .busy      (rdStrobe),
    .remCount  (remCount)
  );

  nbr_datapath #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .ldAddr    (ldAddr),
    .ldSize    (ldSize),
    .extData   (extData),
    .popReq    (popReq),
    .rdAddr    (rdAddr),
    .rdSize    (rdSize),
    .popData   (popData),
    .fillLevel (fillLevel),
    .fifoFull  (fifoFull),
    .underflow (underflow)
  );

  assign atLevel = (fillLevel >= thresh);
  assign irq     = intEn && atLevel;
  assign dmaReq  = dmaEn && atLevel;

endmodule

// File: rtl/nbr_engine_chk.sv
module nbr_engine_chk #(
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          ldValid,
  input logic          wrPending,
  input logic          extEmpty,
  input logic          rdStrobe,
  input logic [AW-1:0] rdAddr,
  input logic [CW-1:0] remCount,
  input logic [LW-1:0] fillLevel,
  input logic          underflow
);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= LW'(DEPTH));

  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStrobe) |-> ($past(fillLevel) < LW'(DEPTH)));

  assert_write_priority_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStrobe) |-> !$past(wrPending));

  assert_empty_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdStrobe) |-> !$past(extEmpty));

  assert_addr_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && $past(rdStrobe) && !$past(ldValid)) |-> $stable(rdAddr));

  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ldValid) |-> (remCount <= $past(remCount)));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(underflow) |-> underflow);

endmodule

bind nbr_engine nbr_engine_chk #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ldValid   (ldValid),
  .wrPending (wrPending),
  .extEmpty  (extEmpty),
  .rdStrobe  (rdStrobe),
  .rdAddr    (rdAddr),
  .remCount  (remCount),
  .fillLevel (fillLevel),
  .underflow (underflow)
);

// File: tb/test_nbr_engine.sv
module test_nbr_engine;

  localparam int AW = 16, DW = 32, CW = 8, DEPTH = 8, RD = 3;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldValid = 1'b0, wrPending = 1'b0, extEmpty = 1'b0, popReq = 1'b0;
  logic intEn = 1'b0, dmaEn = 1'b0;
  logic [AW-1:0] ldAddr = '0;
  logic [1:0]    ldSize = '0;
  logic [CW-1:0] ldCount = '0;
  logic [DW-1:0] extData = 32'h1234_5678;
  logic [LW-1:0] thresh = '0;
  logic [CW-1:0] remCount;
  logic          rdStrobe, underflow, irq, dmaReq;
  logic [AW-1:0] rdAddr;
  logic [1:0]    rdSize;
  logic [DW-1:0] popData;
  logic [LW-1:0] fillLevel;

  always #2 clk = ~clk;

  nbr_engine #(.AW(AW), .DW(DW), .CW(CW), .DEPTH(DEPTH), .RD_CYCLES(RD)) i_nbr_engine (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldAddr(ldAddr), .ldSize(ldSize),
    .ldCount(ldCount), .remCount(remCount), .wrPending(wrPending), .extEmpty(extEmpty),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .rdSize(rdSize), .extData(extData),
    .popReq(popReq), .popData(popData), .fillLevel(fillLevel), .underflow(underflow),
    .thresh(thresh), .intEn(intEn), .dmaEn(dmaEn), .irq(irq), .dmaReq(dmaReq)
  );

  // behavioural reference
  logic [DW-1:0] q[$];
  int  mRem = 0, mTimer = 0, mAddr = 0, mSize = 0;
  bit  mBusy = 0, mUnd = 0;
  int  compared = 0, mismatched = 0, cycles = 0;

  function automatic logic [DW-1:0] shape(logic [DW-1:0] d, int sz);
    if (sz == 0) return {24'h0, d[7:0]};
    if (sz == 1) return {16'h0, d[15:0]};
    return d;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  task automatic modelStep();
    bit cap, lau;
    cap = mBusy && (mTimer == 0);
    lau = !mBusy && (mRem != 0) && !wrPending && !extEmpty && (q.size() < DEPTH);
    if (popReq) begin
      if (q.size() == 0) mUnd = 1;
      else void'(q.pop_front());
    end
    if (cap) q.push_back(shape(extData, mSize));
    if (lau) begin mBusy = 1; mTimer = RD - 1; end
    else if (cap) mBusy = 0;
    else if (mBusy) mTimer--;
    if (ldValid) begin
      mRem = ldCount;
      if (ldCount != 0) begin mAddr = ldAddr; mSize = ldSize; end
      else if (cap) mAddr = (mAddr + ((mSize == 0) ? 1 : (mSize == 1) ? 2 : 4)) & 16'hffff;
    end else begin
      if (cap) mAddr = (mAddr + ((mSize == 0) ? 1 : (mSize == 1) ? 2 : 4)) & 16'hffff;
      if (cap && mRem != 0) mRem--;
    end
  endtask

  // one clock: combinational pop check, edge, model, then compare state
  task automatic cycle();
    #1;
    check("R10", "popData", popData, (popReq && q.size() > 0) ? q[0] : 0);
    @(posedge clk);
    cycles++;
    if (rstN) modelStep();
    @(negedge clk);
    extData = extData * 32'd1103515245 + 32'd12345;
    if (rstN) begin
      check("R2/R11", "rdStrobe", rdStrobe, mBusy);
      check("R2", "rdAddr", rdAddr, mAddr);
      check("R7", "remCount", remCount, mRem);
      check("R6/R3", "fillLevel", fillLevel, q.size());
      check("R10", "underflow", underflow, mUnd);
      check("R9", "irq", irq, intEn && (q.size() >= thresh));
      check("R9", "dmaReq", dmaReq, dmaEn && (q.size() >= thresh));
    end
    ldValid = 1'b0;
    popReq  = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic load(int a, int sz, int cnt);
    ldValid = 1'b1; ldAddr = AW'(a); ldSize = 2'(sz); ldCount = CW'(cnt);
    cycle();
  endtask

  task automatic popN(int n);
    for (int i = 0; i < n; i++) begin popReq = 1'b1; cycle(); end
  endtask

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check("R1", "rdStrobe", rdStrobe, 0);
    check("R1", "remCount", remCount, 0);
    check("R1", "fillLevel", fillLevel, 0);
    check("R1", "underflow", underflow, 0);
    check("R1", "irq/dmaReq", {irq, dmaReq}, 0);
    @(negedge clk);

    // R2 R3 R9: word reads, interrupt at 3
    intEn = 1'b1; thresh = LW'(3);
    load(16'h0100, 2, 4);
    run(20);
    check("R2", "final address word", rdAddr, 16'h0110);
    // R10: ordered pops then empty pop sets sticky flag
    popN(4);
    popN(1);
    check("R10", "sticky underflow", underflow, 1);
    run(2);

    // R4 R5: byte reads, write buffer and external empty hold off launches
    intEn = 1'b0;
    extEmpty = 1'b1;
    load(16'h0200, 0, 3);
    run(6);
    check("R5", "count kept while empty", remCount, 3);
    extEmpty = 1'b0;
    run(2);
    wrPending = 1'b1;   // in-flight read completes, R4
    run(8);
    check("R4", "no launch while writes pending", rdStrobe, 0);
    wrPending = 1'b0;
    run(12);
    popN(3);

    // R6 R9: halfword sequence overfills queue, DMA request at full
    dmaEn = 1'b1; thresh = LW'(DEPTH);
    load(16'h0300, 1, 12);
    run(40);
    check("R6", "paused when full", fillLevel, DEPTH);
    check("R9", "dmaReq at full", dmaReq, 1);
    for (int k = 0; k < 6; k++) begin popReq = 1'b1; cycle(); run(3); end
    run(20);
    popN(9);
    dmaEn = 1'b0;

    // R8: stop load during a read; in-flight result still pushed
    load(16'h0400, 3, 20);
    run(9);
    while (!rdStrobe) cycle();
    ldValid = 1'b1; ldCount = '0;
    cycle();
    run(8);
    check("R8", "stopped count", remCount, 0);
    check("R8", "no further strobe", rdStrobe, 0);
    popN(DEPTH);
    // R9: threshold without enables has no effect
    thresh = '0;
    run(3);
    check("R9", "thresh alone", {irq, dmaReq}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule